// File: doc/BRIEF.md
# Pulse-Skipping Switch Gate Controller

This block drives the gate-enable line of a step-down converter's power switch. It does not vary the duty cycle. A free-running phase counter makes a switching clock with a fixed period and a fixed high time. Each switching cycle then either passes its whole pulse to the gate or drops it entirely. The choice comes from two comparator flags that the block synchronises: the output voltage is below a low limit, or the output voltage is above a high limit. These flags set and clear a hysteresis latch. An enable register copies the latch only at switching-cycle boundaries.

A run of passed cycles followed by a run of dropped cycles gives the modulation factor, which is one minus the ratio of passed cycles to all cycles. To make that ratio visible, the block counts passed and dropped cycles over a window of switching cycles whose length is set at an input. At the end of each window it publishes both totals together with a one-clock strobe. The counters saturate.

Top module: `psm_gate_ctrl`

## Requirements
- R1: `pulse_o` repeats every PERIOD system clocks. It is high for the first ON_CNT clocks of each switching cycle, counted from phase 0, and low for the rest.
- R2: A high on `below_lo_i` reaches the hysteresis latch after two synchronising flops and sets it.
- R3: After two synchronising flops, a high on `above_hi_i` clears the latch. It wins when both flags are high at once. While neither flag is high, the latch keeps its state, so passing or skipping continues unchanged.
- R4: The enable register takes the latch value only at the clock edge that starts a new switching cycle. A latch change during a cycle alters nothing before the next cycle.
- R5: `gate_o` is high only while both `pulse_o` and the enable are high. Every switching cycle therefore carries exactly ON_CNT gate clocks or none at all.
- R6: Each switching cycle is counted as passed if the enable was high during it, and as skipped if it was not. After every `win_len_i` cycles (a value of 0 counts as 1), `stat_pass_o` and `stat_skip_o` load the window totals. In the same step, `stat_valid_o` is high for exactly one clock at phase 0 of the following cycle, and the counts restart from zero.
- R7: The pass and skip counts saturate at 2^CNT_W−1 and never wrap.
- R8: `rst_n` is a synchronous reset, active low. It clears the latch, the enable, the phase counter, the window counters and the published statistics. While `rst_n` is low, `gate_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| below_lo_i | input | 1 | Asynchronous flag: output voltage below the low limit |
| above_hi_i | input | 1 | Asynchronous flag: output voltage above the high limit |
| win_len_i | input | WIN_W | Statistics window length in switching cycles |
| pulse_o | output | 1 | Raw constant-width switching clock |
| gate_o | output | 1 | Gate enable for the power switch |
| stat_pass_o | output | CNT_W | Passed cycles in the last window |
| stat_skip_o | output | CNT_W | Skipped cycles in the last window |
| stat_valid_o | output | 1 | One-clock strobe when new statistics are published |

## Verification
Two events can land on the same edge: the latch changing, and the boundary edge at which the enable samples the latch. The same edge also closes a window, and the cycle just ending must then be classified by the old enable, not the new one. The bench provokes this by raising a flag at phase 0, aligned on the rising edge of `pulse_o`. It then counts gate clocks in that cycle and in the next one, expecting zero followed by ON_CNT, or the reverse. Inside a window it flips the enable on and then off, and checks that the published totals match the gate pulses it observed.

// File: rtl/psm_pkg.sv
// Shared definitions for the pulse-skipping gate controller.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package psm_pkg;
    // Index of each threshold flag in the synchroniser bank.
    typedef enum int {
        FLG_LO = 0,
        FLG_HI = 1
    } flag_idx_e;

    localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/psm_swclk.sv
// Switching-clock generator: a phase counter that wraps every PERIOD clocks.
// It produces a pulse that is high for the first ON_CNT phases, plus a strobe
// on the final phase of each cycle.
// Assumes: 1 <= ON_CNT < PERIOD and PERIOD >= 2.
module psm_swclk #(
    parameter int PERIOD = 250,
    parameter int ON_CNT = 105
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse,
    output logic cyc_end
);
    localparam int PH_W = $clog2(PERIOD);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] PH_ON   = PH_W'(ON_CNT);

    logic [PH_W-1:0] phase_q;

    // Advance the phase and wrap it at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == PH_LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + PH_W'(1);
    end

    // Decode the pulse window and the last phase.
    always_comb begin
        pulse   = (phase_q < PH_ON);
        cyc_end = (phase_q == PH_LAST);
    end
endmodule

// File: rtl/psm_sync2.sv
// Two-flop synchroniser for one asynchronous level flag.
// Assumes: the flag stays stable for longer than two clocks.
module psm_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    // Shift the flag through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/psm_hyst_en.sv
// Hysteresis latch with clear priority. Also holds the enable register that
// copies the latch only at switching-cycle boundaries.
// Assumes: set/clr are already synchronous to clk.
module psm_hyst_en (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic cyc_end,
    output logic latch_q,
    output logic en_q
);
    // Set/clear latch; the clear (above-limit) input dominates.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= 1'b0;
        else if (clr)
            latch_q <= 1'b0;
        else if (set)
            latch_q <= 1'b1;
    end

    // Copy the latch into the enable only when a new cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (cyc_end)
            en_q <= latch_q;
    end
endmodule

// File: rtl/psm_win_stats.sv
// Window statistics: classifies each finished switching cycle as passed or
// skipped, using saturating counters. Publishes both totals every win_len
// cycles with a one-clock strobe.
// Assumes: en is the enable that was in force during the cycle ending at cyc_end.
module psm_win_stats #(
    parameter int WIN_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_end,
    input  logic             en,
    input  logic [WIN_W-1:0] win_len,
    output logic [CNT_W-1:0] stat_pass,
    output logic [CNT_W-1:0] stat_skip,
    output logic             stat_valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] pass_q, skip_q, pass_nx, skip_nx;
    logic [WIN_W-1:0] wcnt_q;
    logic [WIN_W:0]   win_eff, wcnt_p1;
    logic             win_done;

    // Saturating next counts and the end-of-window test.
    always_comb begin
        pass_nx  = (en && pass_q != CNT_MAX)  ? pass_q + CNT_W'(1) : pass_q;
        skip_nx  = (!en && skip_q != CNT_MAX) ? skip_q + CNT_W'(1) : skip_q;
        win_eff  = (win_len == '0) ? (WIN_W+1)'(1) : {1'b0, win_len};
        wcnt_p1  = {1'b0, wcnt_q} + (WIN_W+1)'(1);
        win_done = (wcnt_p1 >= win_eff);
    end

    // Accumulate per cycle; publish and restart at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q     <= '0;
            skip_q     <= '0;
            wcnt_q     <= '0;
            stat_pass  <= '0;
            stat_skip  <= '0;
            stat_valid <= 1'b0;
        end else begin
            stat_valid <= 1'b0;
            if (cyc_end) begin
                if (win_done) begin
                    stat_pass  <= pass_nx;
                    stat_skip  <= skip_nx;
                    stat_valid <= 1'b1;
                    pass_q     <= '0;
                    skip_q     <= '0;
                    wcnt_q     <= '0;
                end else begin
                    pass_q <= pass_nx;
                    skip_q <= skip_nx;
                    wcnt_q <= wcnt_p1[WIN_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/psm_gate_ctrl.sv
// Top of the pulse-skipping gate controller. Synchronises the two threshold
// flags, runs the hysteresis latch and the boundary-sampled enable, and gates
// the constant-width switching pulse. Also gathers pass/skip window statistics.
// Assumes: threshold flags come from comparators with no relation to clk.
module psm_gate_ctrl #(
    parameter int PERIOD = 250,
    parameter int ON_CNT = 105,
    parameter int WIN_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             below_lo_i,
    input  logic             above_hi_i,
    input  logic [WIN_W-1:0] win_len_i,
    output logic             pulse_o,
    output logic             gate_o,
    output logic [CNT_W-1:0] stat_pass_o,
    output logic [CNT_W-1:0] stat_skip_o,
    output logic             stat_valid_o
);
    import psm_pkg::*;

    logic [NUM_FLAGS-1:0] flag_raw, flag_s;
    logic                 lo_s, hi_s, cyc_end, latch_q, en_q;

    // Gather the raw flags into the synchroniser bank.
    always_comb begin
        flag_raw[FLG_LO] = below_lo_i;
        flag_raw[FLG_HI] = above_hi_i;
        lo_s             = flag_s[FLG_LO];
        hi_s             = flag_s[FLG_HI];
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_sync
        psm_sync2 u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (flag_raw[g]),
            .q     (flag_s[g])
        );
    end

    psm_swclk #(.PERIOD(PERIOD), .ON_CNT(ON_CNT)) u_swclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse   (pulse_o),
        .cyc_end (cyc_end)
    );

    psm_hyst_en u_hyst (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (lo_s),
        .clr     (hi_s),
        .cyc_end (cyc_end),
        .latch_q (latch_q),
        .en_q    (en_q)
    );

    psm_win_stats #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_end    (cyc_end),
        .en         (en_q),
        .win_len    (win_len_i),
        .stat_pass  (stat_pass_o),
        .stat_skip  (stat_skip_o),
        .stat_valid (stat_valid_o)
    );

    // Whole-pulse gating; reset forces the gate low at once.
    always_comb gate_o = pulse_o & en_q & rst_n;
endmodule

// File: rtl/psm_gate_ctrl_chk.sv
// Property checker for psm_gate_ctrl, attached with bind.
// Assumes: signals are the top's internal nets named in the bind below.
module psm_gate_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             set,
    input logic             clr,
    input logic             latch,
    input logic             en,
    input logic             cyc_end,
    input logic             pulse,
    input logic             gate,
    input logic             valid,
    input logic [CNT_W-1:0] pass,
    input logic [CNT_W-1:0] skip
);
    p_set_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clr) |=> latch);

    p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !latch);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(latch));

    p_en_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> $stable(en));

    p_en_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> (en == $past(latch)));

    p_gate_whole_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (pulse && en));

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    p_valid_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(cyc_end));

    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (!en && !latch && !valid && pass == '0 && skip == '0));
endmodule

bind psm_gate_ctrl psm_gate_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (lo_s),
    .clr     (hi_s),
    .latch   (latch_q),
    .en      (en_q),
    .cyc_end (cyc_end),
    .pulse   (pulse_o),
    .gate    (gate_o),
    .valid   (stat_valid_o),
    .pass    (stat_pass_o),
    .skip    (stat_skip_o)
);

// File: tb/sim_psm_gate_ctrl.sv
`timescale 1ns/1ps
// Directed bench for psm_gate_ctrl; one task per scenario.
module sim_psm_gate_ctrl;
    localparam int PER = 10;
    localparam int ON  = 4;
    localparam int WW  = 5;
    localparam int CW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          below_lo = 1'b0;
    logic          above_hi = 1'b0;
    logic [WW-1:0] win_len = WW'(4);
    logic          pulse, gate, valid;
    logic [CW-1:0] spass, sskip;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    psm_gate_ctrl #(.PERIOD(PER), .ON_CNT(ON), .WIN_W(WW), .CNT_W(CW)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .below_lo_i   (below_lo),
        .above_hi_i   (above_hi),
        .win_len_i    (win_len),
        .pulse_o      (pulse),
        .gate_o       (gate),
        .stat_pass_o  (spass),
        .stat_skip_o  (sskip),
        .stat_valid_o (valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Stop at the negedge inside phase 0 (pulse has just risen).
    task automatic align();
        logic prv;
        prv = 1'b1;
        forever begin
            @(negedge clk);
            if (pulse && !prv) break;
            prv = pulse;
        end
    endtask

    // From a phase-0 negedge, count gate-high clocks over one cycle.
    task automatic measure(output int hi);
        hi = 0;
        for (int i = 0; i < PER; i++) begin
            if (gate) hi++;
            @(negedge clk);
        end
    endtask

    task automatic wait_valid();
        forever begin
            @(negedge clk);
            if (valid) break;
        end
    endtask

    task automatic go_on();
        int h;
        align();
        below_lo = 1'b1;
        measure(h);
        below_lo = 1'b0;
        measure(h);
    endtask

    task automatic go_off();
        int h;
        align();
        above_hi = 1'b1;
        measure(h);
        above_hi = 1'b0;
        measure(h);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R8 gate in reset", int'(gate), 0);
        chk("R8 valid in reset", int'(valid), 0);
        chk("R8 pass in reset", int'(spass), 0);
        rst_n = 1'b1;
        repeat (2 * PER) begin
            @(negedge clk);
            if (gate) chk("R8 gate after reset", 1, 0);
        end
        chk("R8 skip after reset", int'(sskip), 0);
    endtask

    task automatic t_pulse_shape();
        int hi, len;
        align();
        hi = 0;
        len = 0;
        do begin
            if (pulse) hi++;
            len++;
            @(negedge clk);
        end while (!(pulse && len > 1 && hi == ON) && len < 4 * PER);
        chk("R1 period", len, PER);
        chk("R1 high time", hi, ON);
    endtask

    task automatic t_enable_timing();
        int h0, h1;
        align();
        below_lo = 1'b1;
        measure(h0);
        below_lo = 1'b0;
        measure(h1);
        chk("R4 enable not in same cycle", h0, 0);
        chk("R2 R5 full pulse after set", h1, ON);
    endtask

    task automatic t_hold_on();
        int h;
        for (int c = 0; c < 3; c++) begin
            measure(h);
            chk("R3 latch holds passing", h, ON);
        end
    endtask

    task automatic t_disable_timing();
        int h0, h1, h2;
        align();
        above_hi = 1'b1;
        measure(h0);
        above_hi = 1'b0;
        measure(h1);
        measure(h2);
        chk("R4 disable not in same cycle", h0, ON);
        chk("R3 skipped after clear", h1, 0);
        chk("R3 latch holds skipping", h2, 0);
    endtask

    task automatic t_priority();
        int h0, h1;
        align();
        below_lo = 1'b1;
        above_hi = 1'b1;
        measure(h0);
        measure(h1);
        below_lo = 1'b0;
        above_hi = 1'b0;
        chk("R3 both flags from off", h0 + h1, 0);
        go_on();
        align();
        below_lo = 1'b1;
        above_hi = 1'b1;
        measure(h0);
        measure(h1);
        below_lo = 1'b0;
        above_hi = 1'b0;
        chk("R3 both flags from on, current cycle", h0, ON);
        chk("R3 both flags from on, clear wins", h1, 0);
    endtask

    task automatic t_window();
        int h0, h1, h2, h3;
        go_on();
        wait_valid();
        wait_valid();
        chk("R6 all-pass count", int'(spass), 4);
        chk("R6 all-pass skip", int'(sskip), 0);
        @(negedge clk);
        chk("R6 strobe one clock", int'(valid), 0);
        go_off();
        wait_valid();
        wait_valid();
        chk("R6 all-skip count", int'(sskip), 4);
        chk("R6 all-skip pass", int'(spass), 0);
        below_lo = 1'b1;
        measure(h0);
        below_lo = 1'b0;
        above_hi = 1'b1;
        measure(h1);
        above_hi = 1'b0;
        measure(h2);
        measure(h3);
        chk("R6 strobe at window end", int'(valid), 1);
        chk("R6 mixed pass", int'(spass), (h0 + h1 + h2 + h3) / ON);
        chk("R6 mixed pass fixed", int'(spass), 1);
        chk("R6 mixed skip", int'(sskip), 3);
    endtask

    task automatic t_saturation();
        win_len = WW'(10);
        go_on();
        wait_valid();
        wait_valid();
        chk("R7 pass saturates", int'(spass), 7);
        chk("R7 skip zero", int'(sskip), 0);
    endtask

    task automatic t_win_zero();
        int gap;
        win_len = '0;
        wait_valid();
        wait_valid();
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!valid && gap < 4 * PER);
        chk("R6 zero length acts as one", gap, PER);
        chk("R6 zero length pass", int'(spass), 1);
        win_len = WW'(4);
    endtask

    task automatic t_mid_reset();
        align();
        chk("R5 gate on before reset", int'(gate), 1);
        rst_n = 1'b0;
        #1;
        chk("R8 gate drops in reset", int'(gate), 0);
        repeat (3) @(negedge clk);
        chk("R8 stats cleared", int'(spass) + int'(sskip) + int'(valid), 0);
        rst_n = 1'b1;
        repeat (2 * PER) begin
            @(negedge clk);
            if (gate) chk("R8 enable cleared by reset", 1, 0);
        end
    endtask

    initial begin
        t_reset();
        t_pulse_shape();
        t_enable_timing();
        t_hold_on();
        t_disable_timing();
        t_priority();
        t_window();
        t_saturation();
        t_win_zero();
        t_mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule